// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two independent up-counters, timer 0 and timer 1, each built from a low byte and a high byte. Each timer counts one of two sources: machine-cycle ticks, which come every PRESCALE core clocks, or falling edges on its own external count pin. A per-timer gate bit can hand the start and stop of counting to an external gate pin, so the width of a pulse can be measured. Each timer has four count layouts: a 13-bit counter, a 16-bit counter, an 8-bit counter that reloads itself, and a split layout. The split layout turns timer 0 into two separate 8-bit counters and gives timer 0's high byte the run bit and the overflow flag of timer 1.

Software reaches the counters, the configuration and the flags through a byte-wide register port. The write side is synchronous and the read side is combinational. When a timer overflows, it sets a sticky flag, which is visible on a port for an interrupt controller. An acknowledge input clears the flag, and so does a write-one-to-clear on the control register. Every timer 1 overflow also produces a one-cycle strobe, which a baud-rate generator can use. The count and gate pins pass through a synchronizer of SYNC_STAGES flops.

Top module: `tmr_pair`

## Requirements
- R1: Register map by address: 0 = timer 0 low byte, 1 = timer 0 high byte, 2 = timer 1 low byte, 3 = timer 1 high byte. Address 4 = config, with bits [1:0] timer 0 layout, bit 2 timer 0 pin-count select, bit 3 timer 0 gate enable, and bits [5:4], 6, 7 holding the same fields for timer 1. Address 5 = control, with bit 0 run 0, bit 1 run 1, bit 2 flag 0 and bit 3 flag 1. After reset every register, both flags and the tick strobe are zero.
- R2: With pin-count select at 0, a running timer advances by exactly one every PRESCALE (default 12) clocks.
- R3: With pin-count select at 1, each falling edge of the timer's count pin advances it by exactly one, and rising edges have no effect.
- R4: A timer advances only while its run bit is 1 and, when its gate enable is 1, its gate pin is also high.
- R5: Layout 0 counts the 13-bit value {high byte, low byte[4:0]}. Low byte bits [7:5] keep whatever was written to them and do not affect the count. Going from all ones to zero sets the flag.
- R6: Layout 1 counts the 16-bit value {high, low}. Going from 0xFFFF to 0x0000 sets the flag.
- R7: Layout 2 counts the low byte only. When the low byte passes 0xFF, it is loaded from the high byte and the flag is set. The high byte never changes.
- R8: Setting a run bit leaves the count bytes unchanged.
- R9: Timer 1 in layout 3 holds its count whatever its run bit is.
- R10: Timer 0 in layout 3 splits into two counters. The low byte counts as an 8-bit counter under timer 0's run bit, gate and source, and sets flag 0. The high byte counts machine cycles only, runs under the run 1 bit, and sets flag 1 when it wraps.
- R11: While timer 0 is in layout 3, timer 1 counts regardless of its run bit and is stopped only by its own layout 3. Its overflows no longer set flag 1.
- R12: A flag is cleared by a one-cycle pulse on its acknowledge input, or by writing 1 to its bit at address 5. Writing 0 to a flag bit leaves it as it is.
- R13: A register write to a count byte wins over an increment of that byte in the same cycle.
- R14: Every timer 1 overflow produces a strobe on the tick output that is high for exactly one clock, in any layout of timer 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| cnt_in | input | 2 | External count pins, index = timer |
| gate_in | input | 2 | External gate pins, index = timer |
| flag_ack | input | 2 | Flag acknowledge pulses, index = timer |
| ovf_flag | output | 2 | Sticky overflow flags |
| t1_ovf_tick | output | 1 | One-clock strobe per timer 1 overflow |

## Verification
Random start values and random run windows are used in layouts 0, 1 and 2 on both timers, with about half of the starts placed near the top of the range. These runs separate a correct carry chain and wrap point from an off-by-one in the prescaler window. They also show whether the 13-bit layout leaves the three unused low-byte bits alone. Directed sequences cover the other cases:
- pin edges against rising edges;
- a gate pin held low against one held high;
- the split layout driven by each run bit in turn, which shows which byte answers which run bit and which flag;
- a write timed to the exact cycle in which a synchronized pin edge would increment the same byte.

// File: rtl/tmr_pair.sv
module tmr_pair #(
  parameter int PRESCALE    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [1:0] cnt_in,
  input  logic [1:0] gate_in,
  input  logic [1:0] flag_ack,
  output logic [1:0] ovf_flag,
  output logic       t1_ovf_tick
);
  localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PLAST = PW'(PRESCALE - 1);
  localparam logic [2:0] A_CFG = 3'd4;
  localparam logic [2:0] A_CTL = 3'd5;

  logic [PW-1:0] pcnt;
  logic          tick;
  logic [1:0][SYNC_STAGES-1:0] cpipe, gpipe;
  logic [1:0] csync, gsync, cold, fall;
  logic [1:0][7:0] lo, hi, nlo, nhi;
  logic [7:0] cfg;
  logic [1:0] run, flag;
  logic [1:0][1:0] mode;
  logic [1:0] ct, gate, qual, src, en, ov, set, clr, wr_lo, wr_hi;
  logic t0_split, en_h0, ovh;

  assign tick = (pcnt == PLAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pcnt <= '0;
    else        pcnt <= tick ? '0 : pcnt + PW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cpipe <= '0;
      gpipe <= '0;
      cold  <= '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        cpipe[i] <= {cpipe[i][SYNC_STAGES-2:0], cnt_in[i]};
        gpipe[i] <= {gpipe[i][SYNC_STAGES-2:0], gate_in[i]};
      end
      cold <= csync;
    end

  always_comb
    for (int i = 0; i < 2; i++) begin
      csync[i] = cpipe[i][SYNC_STAGES-1];
      gsync[i] = gpipe[i][SYNC_STAGES-1];
    end

  assign fall = cold & ~csync;

  assign mode[0] = cfg[1:0];
  assign ct[0]   = cfg[2];
  assign gate[0] = cfg[3];
  assign mode[1] = cfg[5:4];
  assign ct[1]   = cfg[6];
  assign gate[1] = cfg[7];

  assign t0_split = (mode[0] == 2'd3);
  assign qual     = ~gate | gsync;

  always_comb
    for (int i = 0; i < 2; i++) src[i] = ct[i] ? fall[i] : tick;

  assign en[0] = run[0] & qual[0] & src[0];
  assign en[1] = (t0_split | run[1]) & qual[1] & src[1] & (mode[1] != 2'd3);
  assign en_h0 = t0_split & run[1] & tick;

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      nlo[i] = lo[i];
      nhi[i] = hi[i];
      ov[i]  = 1'b0;
      if (en[i]) begin
        case (mode[i])
          2'd0: begin
            nlo[i][4:0] = lo[i][4:0] + 5'd1;
            if (&lo[i][4:0]) nhi[i] = hi[i] + 8'd1;
            ov[i] = (&lo[i][4:0]) & (&hi[i]);
          end
          2'd1: begin
            {nhi[i], nlo[i]} = {hi[i], lo[i]} + 16'd1;
            ov[i] = &{hi[i], lo[i]};
          end
          2'd2: begin
            ov[i]  = &lo[i];
            nlo[i] = (&lo[i]) ? hi[i] : lo[i] + 8'd1;
          end
          default: begin
            nlo[i] = lo[i] + 8'd1;
            ov[i]  = &lo[i];
          end
        endcase
      end
    end
    ovh = en_h0 & (&hi[0]);
    if (en_h0) nhi[0] = hi[0] + 8'd1;
  end

  assign set[0] = ov[0];
  assign set[1] = t0_split ? ovh : ov[1];

  always_comb
    for (int i = 0; i < 2; i++) begin
      wr_lo[i] = bus_we && (bus_addr == 3'(2 * i));
      wr_hi[i] = bus_we && (bus_addr == 3'(2 * i + 1));
      clr[i]   = flag_ack[i] | (bus_we && (bus_addr == A_CTL) && bus_wdata[2+i]);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lo          <= '0;
      hi          <= '0;
      cfg         <= '0;
      run         <= '0;
      flag        <= '0;
      t1_ovf_tick <= 1'b0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        lo[i]   <= wr_lo[i] ? bus_wdata : nlo[i];
        hi[i]   <= wr_hi[i] ? bus_wdata : nhi[i];
        flag[i] <= set[i] | (flag[i] & ~clr[i]);
      end
      if (bus_we && bus_addr == A_CFG) cfg <= bus_wdata;
      if (bus_we && bus_addr == A_CTL) run <= bus_wdata[1:0];
      t1_ovf_tick <= ov[1];
    end

  assign ovf_flag = flag;

  always_comb
    case (bus_addr)
      3'd0:    bus_rdata = lo[0];
      3'd1:    bus_rdata = hi[0];
      3'd2:    bus_rdata = lo[1];
      3'd3:    bus_rdata = hi[1];
      A_CFG:   bus_rdata = cfg;
      A_CTL:   bus_rdata = {4'b0, flag, run};
      default: bus_rdata = 8'h00;
    endcase

  p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  p_stopped_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run[0] && !t0_split && !(bus_we && bus_addr < 3'd2)) |=> ($stable(lo[0]) && $stable(hi[0])));

  p_wrap_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[0] == 2'd1 && en[0] && lo[0] == 8'hFF && hi[0] == 8'hFF) |=> ovf_flag[0]);

  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[0] == 2'd2 && en[0] && lo[0] == 8'hFF && !(bus_we && bus_addr < 3'd2))
      |=> (lo[0] == $past(hi[0]) && $stable(hi[0])));

  p_t1_parked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] == 2'd3 && !(bus_we && (bus_addr == 3'd2 || bus_addr == 3'd3)))
      |=> ($stable(lo[1]) && $stable(hi[1])));

  p_t1_no_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_split && !ovh && !ovf_flag[1]) |=> !ovf_flag[1]);

  p_strobe_one_r14: assert property (@(posedge clk) disable iff (!rst_n)
    t1_ovf_tick |=> !t1_ovf_tick);
endmodule

// File: tb/tb_tmr_pair.sv
module tb_tmr_pair;
  localparam int PS = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [1:0] cnt_in = '0;
  logic [1:0] gate_in = '0;
  logic [1:0] flag_ack = '0;
  logic [1:0] ovf_flag;
  logic       t1_ovf_tick;

  int checks = 0;
  int failures = 0;
  int strobes = 0;
  bit done = 0;

  tmr_pair #(.PRESCALE(PS), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_in(cnt_in),
    .gate_in(gate_in), .flag_ack(flag_ack), .ovf_flag(ovf_flag),
    .t1_ovf_tick(t1_ovf_tick)
  );

  always #10 clk = ~clk;

  always @(negedge clk) if (t1_ovf_tick) strobes++;

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic window(input logic [2:0] a, input logic [7:0] on, input logic [7:0] off, input int n);
    wr(a, on);
    repeat (PS * n - 1) @(negedge clk);
    wr(a, off);
  endtask

  function automatic logic [16:0] step(input logic [1:0] m, input logic [15:0] v);
    logic [12:0] c;
    logic [15:0] r;
    logic o;
    r = v; o = 1'b0; c = {v[15:8], v[4:0]};
    case (m)
      2'd0: begin o = (c == 13'h1FFF); c = c + 13'd1; r = {c[12:5], v[7:5], c[4:0]}; end
      2'd1: begin o = (v == 16'hFFFF); r = v + 16'd1; end
      default: begin o = (v[7:0] == 8'hFF); r[7:0] = o ? v[15:8] : v[7:0] + 8'd1; end
    endcase
    return {o, r};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, l0, h0;
    logic [15:0] v;
    logic [16:0] s;
    int n, ovc;
    logic [1:0] m;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int a = 0; a < 6; a++) begin
      rd(3'(a), r);
      chk("R1 reset reg", {8'h0, r}, 16'h0);
    end
    chk("R1 reset flags/strobe", {13'h0, ovf_flag, t1_ovf_tick}, 16'h0);

    wr(4, 8'h01); wr(0, 8'h10); wr(1, 8'h00);
    window(5, 8'h01, 8'h00, 5);
    rd(0, r); chk("R2 tick count lo", {8'h0, r}, 16'h15);

    wr(4, 8'h00); wr(0, 8'hFF); wr(1, 8'hFF); wr(5, 8'h0C);
    window(5, 8'h01, 8'h00, 1);
    rd(0, l0); rd(1, h0);
    chk("R5 wrap 13-bit", {h0, l0}, 16'h00E0);
    chk("R5 flag set", {15'h0, ovf_flag[0]}, 16'h1);
    wr(0, 8'hBE); wr(1, 8'h12);
    window(5, 8'h01, 8'h00, 3);
    rd(0, l0); rd(1, h0);
    chk("R5 carry, upper bits kept", {h0, l0}, 16'h13A1);

    flag_ack[0] = 1'b1; @(negedge clk); flag_ack[0] = 1'b0;
    chk("R12 ack clears", {15'h0, ovf_flag[0]}, 16'h0);

    wr(4, 8'h01); wr(0, 8'hFE); wr(1, 8'hFF);
    window(5, 8'h01, 8'h00, 2);
    rd(0, l0); rd(1, h0);
    chk("R6 16-bit wrap", {h0, l0}, 16'h0000);
    chk("R6 flag", {15'h0, ovf_flag[0]}, 16'h1);
    wr(5, 8'h00);
    chk("R12 zero write keeps flag", {15'h0, ovf_flag[0]}, 16'h1);
    wr(5, 8'h04);
    chk("R12 w1c clears", {15'h0, ovf_flag[0]}, 16'h0);

    wr(4, 8'h02); wr(0, 8'hFE); wr(1, 8'hF0);
    window(5, 8'h01, 8'h00, 3);
    rd(0, l0); rd(1, h0);
    chk("R7 reload", {h0, l0}, 16'hF0F1);
    chk("R7 flag", {15'h0, ovf_flag[0]}, 16'h1);
    wr(5, 8'h04);

    gate_in[0] = 1'b0;
    wr(4, 8'h09); wr(0, 8'h33); wr(1, 8'h44);
    wr(5, 8'h01);
    repeat (30) @(negedge clk);
    rd(0, l0); rd(1, h0);
    chk("R8 run keeps count", {h0, l0}, 16'h4433);
    wr(5, 8'h00);
    wr(0, 8'h00); wr(1, 8'h00);
    window(5, 8'h01, 8'h00, 5);
    rd(0, r); chk("R4 gate low blocks", {8'h0, r}, 16'h0);
    gate_in[0] = 1'b1;
    repeat (4) @(negedge clk);
    window(5, 8'h01, 8'h00, 5);
    rd(0, r); chk("R4 gate high counts", {8'h0, r}, 16'h5);
    gate_in[0] = 1'b0;
    wr(4, 8'h01);
    repeat (PS * 3) @(negedge clk);
    rd(0, r); chk("R4 run low holds", {8'h0, r}, 16'h5);

    wr(4, 8'h05); wr(0, 8'h00); wr(1, 8'h00); wr(5, 8'h01);
    for (int k = 0; k < 5; k++) begin
      cnt_in[0] = 1'b1; repeat (3) @(negedge clk);
      cnt_in[0] = 1'b0; repeat (3) @(negedge clk);
    end
    cnt_in[0] = 1'b1; repeat (5) @(negedge clk);
    rd(0, r); chk("R3 falling edges only", {8'h0, r}, 16'h5);

    cnt_in[0] = 1'b0;
    @(negedge clk); @(negedge clk);
    wr(0, 8'h40);
    repeat (4) @(negedge clk);
    rd(0, l0); rd(1, h0);
    chk("R13 write wins", {h0, l0}, 16'h0040);
    wr(5, 8'h00);

    wr(4, 8'h30); wr(2, 8'h12); wr(3, 8'h34);
    window(5, 8'h02, 8'h00, 5);
    rd(2, l0); rd(3, h0);
    chk("R9 t1 parked", {h0, l0}, 16'h3412);

    wr(4, 8'h33); wr(0, 8'h00); wr(1, 8'hFE); wr(5, 8'h0C);
    window(5, 8'h02, 8'h00, 3);
    rd(0, l0); rd(1, h0);
    chk("R10 high byte on run1", {h0, l0}, 16'h0100);
    chk("R10 flags", {14'h0, ovf_flag}, 16'h2);
    wr(5, 8'h0C); wr(0, 8'hFE);
    window(5, 8'h01, 8'h00, 3);
    rd(0, l0); rd(1, h0);
    chk("R10 low byte on run0", {h0, l0}, 16'h0101);
    chk("R10 flag0", {14'h0, ovf_flag}, 16'h1);

    wr(5, 8'h0C); wr(2, 8'hFE); wr(3, 8'hFF);
    @(negedge clk); strobes = 0;
    window(4, 8'h23, 8'h33, 4);
    @(negedge clk);
    rd(2, r);
    chk("R11 t1 runs without run1", {8'h0, r}, 16'hFF);
    chk("R11 strobes", 16'(strobes), 16'd3);
    chk("R11 no flag1", {15'h0, ovf_flag[1]}, 16'h0);

    wr(4, 8'h20); wr(2, 8'hFE); wr(3, 8'hFF);
    @(negedge clk); strobes = 0;
    window(5, 8'h02, 8'h00, 4);
    @(negedge clk);
    chk("R14 strobes", 16'(strobes), 16'd3);
    chk("R14 flag1", {15'h0, ovf_flag[1]}, 16'h1);

    for (int it = 0; it < 16; it++) begin
      int t;
      t = it % 2;
      m = 2'($urandom_range(0, 2));
      v = 16'($urandom);
      if ($urandom_range(0, 1) == 1) v = (m == 2'd2) ? {v[15:8], 8'hF0 | v[3:0]} : 16'hFFE0 | v[4:0];
      n = $urandom_range(1, 30);
      wr(4, t == 1 ? {2'b00, m, 4'h0} : {4'h0, 2'b00, m});
      wr(3'(2 * t), v[7:0]); wr(3'(2 * t + 1), v[15:8]); wr(5, 8'h0C);
      @(negedge clk); strobes = 0;
      ovc = 0;
      for (int k = 0; k < n; k++) begin
        s = step(m, v);
        v = s[15:0];
        if (s[16]) ovc++;
      end
      window(5, t == 1 ? 8'h02 : 8'h01, 8'h00, n);
      @(negedge clk);
      rd(3'(2 * t), l0); rd(3'(2 * t + 1), h0);
      chk(t == 1 ? "R5/R6/R7 random t1" : "R5/R6/R7 random t0", {h0, l0}, v);
      chk("R6 random flag", {15'h0, ovf_flag[t]}, {15'h0, ovc > 0});
      if (t == 1) chk("R14 random strobes", 16'(strobes), 16'(ovc));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule